// File: doc/BRIEF.md
# Target Reset and Startup Sequencer

This block runs the reset ceremony that opens a debug session on a target board. On a start request it pulls the target's system reset line and its JTAG test-reset line for a programmable number of milliseconds. It then releases both and waits a programmable wake-up time. After that it either requests a halt at once, lets the target run for a bounded time and then requests a halt, or leaves the target running until an outside agent asks for a halt. The time base is a one-cycle millisecond tick supplied from outside, so the block itself never divides the clock.

The mode and every duration are captured when a start request is accepted, so a later change on those inputs does not disturb a sequence already in progress. The TRST pin can be driven open-drain or push-pull, and driving of the system reset pin can be switched off entirely. A downstream engine that works through the initialisation list waits on the ready flag. The halt request is a single-cycle pulse for the debug-halt logic.

Top module: `tgt_boot_seq`

## Requirements
- R1: After synchronous reset, no pin is pulled (`sys_rst_oe`=0, and `trst_oe`=0 when open-drain is selected), `trst_lvl`=0, and `halt_req`, `init_ready`, `busy` and `running` are all 0.
- R2: An accepted start request asserts the system reset and TRST for exactly the captured assert time, counted in `ms_tick` pulses. A captured assert value of 0 selects the default of `DEF_ASSERT_MS` (3) ticks.
- R3: With `rst_drive_en`=0 captured at start, `sys_rst_oe` stays 0 for the whole sequence, and all timing is otherwise unchanged.
- R4: With `trst_push_pull`=0 (open-drain), `trst_lvl` is always 0 and `trst_oe`=1 only while TRST is asserted. With `trst_push_pull`=1, `trst_oe`=1 at all times and `trst_lvl` is 0 while asserted and 1 otherwise.
- R5: After reset release the block waits exactly `wake_ms` ticks (0 means no wait) before any halt or run decision. During the wait `busy`=1, there is no halt pulse and `running`=0.
- R6: In mode 0 (reset-halt), the end of the wake wait gives exactly one single-cycle `halt_req` pulse, after which `init_ready`=1 and `busy`=0.
- R7: In mode 1 (timed), the target runs for the effective run time in ticks after the wake wait. Then exactly one `halt_req` pulse follows and `init_ready` becomes 1.
- R8: The effective run time is `run_ms` clamped into [`RUN_MIN`, `RUN_MAX`] (defaults 100 and 32000).
- R9: In mode 2 or 3 (free-run), after the wake wait `running`=1 and `busy`=0, and no halt is requested until `ext_halt` is seen. That gives one `halt_req` pulse, then `init_ready`=1 and `running`=0. `ext_halt` in any other state has no effect.
- R10: `busy` is 1 from an accepted start until ready or running is reached. A start request while busy is ignored. A start from idle, ready or running restarts the sequence and clears `init_ready`.
- R11: Mode, assert time, wake time, run time and reset-drive enable are captured at the accepted start. Later changes on those inputs do not alter the running sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ms_tick | input | 1 | One-cycle pulse per millisecond |
| start_req | input | 1 | Begin a startup sequence |
| mode_sel | input | 2 | 0 reset-halt, 1 timed, 2/3 free-run |
| assert_ms | input | DLY_W | Reset assert time in ms (0 = default) |
| wake_ms | input | DLY_W | Delay after release in ms |
| run_ms | input | RUN_W | Run time before halt in timed mode |
| rst_drive_en | input | 1 | Allow pulling the system reset line |
| trst_push_pull | input | 1 | 1 = TRST push-pull, 0 = open-drain |
| ext_halt | input | 1 | Halt request from debugger in free-run |
| sys_rst_oe | output | 1 | Pull system reset low |
| trst_oe | output | 1 | TRST output enable |
| trst_lvl | output | 1 | TRST level when enabled |
| halt_req | output | 1 | Single-cycle request to enter debug mode |
| init_ready | output | 1 | Target halted, init list may start |
| busy | output | 1 | Sequence in progress |
| running | output | 1 | Target left running in free-run mode |

## Verification
On every cycle the assertions check several properties: the open-drain TRST level never goes high, the reset pin is never pulled without the captured drive enable, the halt pulse lasts one cycle, the tick counter holds still between ticks, a busy sequence never falls back into reset, and a free-running target stays free until asked. Only the bench scenarios can show the exact tick counts of the assert, wake and run windows, the default and the clamping of durations, the captured configuration surviving later input changes, and the pin levels in each driver type. The bench sweeps mode, assert time, wake time, driver type and run time over a small parameter set.

// File: rtl/boot_seq_pkg.sv
package boot_seq_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_HOLD,
    ST_WAKE,
    ST_RUNWAIT,
    ST_HALT,
    ST_READY,
    ST_RUNNING
  } seq_st_t;

  typedef enum logic [1:0] {
    MODE_RST_HALT = 2'd0,
    MODE_TIMED    = 2'd1,
    MODE_FREE     = 2'd2,
    MODE_FREE_ALT = 2'd3
  } boot_mode_t;

endpackage

// File: rtl/boot_ms_timer.sv
module boot_ms_timer #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clear,
  input  logic             tick,
  input  logic [CNT_W-1:0] target,
  output logic             done
);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W:0]   cnt_nxt;

  assign cnt_nxt = {1'b0, cnt_q} + {{CNT_W{1'b0}}, tick};
  assign done    = cnt_nxt >= {1'b0, target};

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      cnt_q <= '0;
    end else if (tick && (cnt_q != {CNT_W{1'b1}})) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  AST_CNT_HOLDS: assert property (@(posedge clk) disable iff (rst)
    (!clear && !tick) |=> $stable(cnt_q)); // R2

endmodule

// File: rtl/boot_seq_fsm.sv
module boot_seq_fsm
  import boot_seq_pkg::*;
#(
  parameter int DLY_W         = 8,
  parameter int RUN_W         = 16,
  parameter int RUN_MIN       = 100,
  parameter int RUN_MAX       = 32000,
  parameter int DEF_ASSERT_MS = 3,
  parameter int CNT_W         = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start_req,
  input  logic [1:0]       mode_sel,
  input  logic [DLY_W-1:0] assert_ms,
  input  logic [DLY_W-1:0] wake_ms,
  input  logic [RUN_W-1:0] run_ms,
  input  logic             rst_drive_en,
  input  logic             ext_halt,
  input  logic             tmr_done,
  output logic             tmr_clear,
  output logic [CNT_W-1:0] tmr_target,
  output seq_st_t          state,
  output logic             drive_en
);

  localparam logic [RUN_W-1:0] RMIN = RUN_W'(RUN_MIN);
  localparam logic [RUN_W-1:0] RMAX = RUN_W'(RUN_MAX);
  localparam logic [DLY_W-1:0] ADEF = DLY_W'(DEF_ASSERT_MS);

  seq_st_t          state_q, state_d;
  boot_mode_t       mode_q;
  logic [DLY_W-1:0] asrt_q, wake_q;
  logic [RUN_W-1:0] run_q, run_clamped;
  logic             drive_q;
  logic             start_ok;

  assign start_ok = start_req &&
                    (state_q == ST_IDLE || state_q == ST_READY || state_q == ST_RUNNING);

  always_comb begin
    if (run_ms < RMIN)      run_clamped = RMIN;
    else if (run_ms > RMAX) run_clamped = RMAX;
    else                    run_clamped = run_ms;
  end

  always_comb begin
    case (state_q)
      ST_HOLD:    tmr_target = CNT_W'(asrt_q);
      ST_WAKE:    tmr_target = CNT_W'(wake_q);
      ST_RUNWAIT: tmr_target = CNT_W'(run_q);
      default:    tmr_target = '0;
    endcase
  end

  always_comb begin
    state_d   = state_q;
    tmr_clear = 1'b0;
    case (state_q)
      ST_IDLE, ST_READY: begin
        if (start_ok) begin
          state_d   = ST_HOLD;
          tmr_clear = 1'b1;
        end
      end
      ST_RUNNING: begin
        if (start_ok) begin
          state_d   = ST_HOLD;
          tmr_clear = 1'b1;
        end else if (ext_halt) begin
          state_d = ST_HALT;
        end
      end
      ST_HOLD: begin
        if (tmr_done) begin
          state_d   = ST_WAKE;
          tmr_clear = 1'b1;
        end
      end
      ST_WAKE: begin
        if (tmr_done) begin
          tmr_clear = 1'b1;
          case (mode_q)
            MODE_RST_HALT: state_d = ST_HALT;
            MODE_TIMED:    state_d = ST_RUNWAIT;
            default:       state_d = ST_RUNNING;
          endcase
        end
      end
      ST_RUNWAIT: begin
        if (tmr_done) begin
          state_d   = ST_HALT;
          tmr_clear = 1'b1;
        end
      end
      ST_HALT:  state_d = ST_READY;
      default:  state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      mode_q  <= MODE_RST_HALT;
      asrt_q  <= ADEF;
      wake_q  <= '0;
      run_q   <= RMIN;
      drive_q <= 1'b0;
    end else begin
      state_q <= state_d;
      if (start_ok) begin
        mode_q  <= boot_mode_t'(mode_sel);
        asrt_q  <= (assert_ms == '0) ? ADEF : assert_ms;
        wake_q  <= wake_ms;
        run_q   <= run_clamped;
        drive_q <= rst_drive_en;
      end
    end
  end

  assign state    = state_q;
  assign drive_en = drive_q;

  AST_BUSY_NO_RESTART: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_WAKE || state_q == ST_RUNWAIT || state_q == ST_HALT)
      |=> state_q != ST_HOLD); // R10

  AST_FREE_STAYS: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_RUNNING && !ext_halt && !start_req) |=> state_q == ST_RUNNING); // R9

  AST_HALT_ONLY_FROM_WAIT: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_HALT) |-> ($past(state_q) == ST_WAKE || $past(state_q) == ST_RUNWAIT
                              || $past(state_q) == ST_RUNNING)); // R6

endmodule

// File: rtl/boot_pin_drv.sv
module boot_pin_drv
  import boot_seq_pkg::*;
(
  input  logic    clk,
  input  logic    rst,
  input  seq_st_t state,
  input  logic    drive_en,
  input  logic    trst_pp,
  output logic    sys_rst_oe,
  output logic    trst_oe,
  output logic    trst_lvl,
  output logic    halt_req,
  output logic    init_ready,
  output logic    busy,
  output logic    running
);

  logic in_hold;
  assign in_hold = (state == ST_HOLD);

  always_ff @(posedge clk) begin
    if (rst) begin
      sys_rst_oe <= 1'b0;
      trst_oe    <= 1'b0;
      trst_lvl   <= 1'b0;
      halt_req   <= 1'b0;
      init_ready <= 1'b0;
      busy       <= 1'b0;
      running    <= 1'b0;
    end else begin
      sys_rst_oe <= in_hold && drive_en;
      trst_oe    <= trst_pp ? 1'b1 : in_hold;
      trst_lvl   <= trst_pp ? !in_hold : 1'b0;
      halt_req   <= (state == ST_HALT);
      init_ready <= (state == ST_READY);
      busy       <= (state == ST_HOLD) || (state == ST_WAKE) ||
                    (state == ST_RUNWAIT) || (state == ST_HALT);
      running    <= (state == ST_RUNNING);
    end
  end

  AST_OD_NEVER_HIGH: assert property (@(posedge clk) disable iff (rst)
    trst_lvl |-> $past(trst_pp)); // R4

  AST_RST_GATED: assert property (@(posedge clk) disable iff (rst)
    sys_rst_oe |-> $past(drive_en)); // R3

  AST_HALT_PULSE: assert property (@(posedge clk) disable iff (rst)
    halt_req |=> !halt_req); // R6

endmodule

// File: rtl/tgt_boot_seq.sv
module tgt_boot_seq
  import boot_seq_pkg::*;
#(
  parameter int DLY_W         = 8,
  parameter int RUN_W         = 16,
  parameter int RUN_MIN       = 100,
  parameter int RUN_MAX       = 32000,
  parameter int DEF_ASSERT_MS = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ms_tick,
  input  logic             start_req,
  input  logic [1:0]       mode_sel,
  input  logic [DLY_W-1:0] assert_ms,
  input  logic [DLY_W-1:0] wake_ms,
  input  logic [RUN_W-1:0] run_ms,
  input  logic             rst_drive_en,
  input  logic             trst_push_pull,
  input  logic             ext_halt,
  output logic             sys_rst_oe,
  output logic             trst_oe,
  output logic             trst_lvl,
  output logic             halt_req,
  output logic             init_ready,
  output logic             busy,
  output logic             running
);

  localparam int CNT_W = (DLY_W > RUN_W) ? DLY_W : RUN_W;

  logic             tmr_clear, tmr_done, drive_en;
  logic [CNT_W-1:0] tmr_target;
  seq_st_t          state;

  boot_ms_timer #(.CNT_W(CNT_W)) u_timer (
    .clk    (clk),
    .rst    (rst),
    .clear  (tmr_clear),
    .tick   (ms_tick),
    .target (tmr_target),
    .done   (tmr_done)
  );

  boot_seq_fsm #(
    .DLY_W(DLY_W), .RUN_W(RUN_W), .RUN_MIN(RUN_MIN), .RUN_MAX(RUN_MAX),
    .DEF_ASSERT_MS(DEF_ASSERT_MS), .CNT_W(CNT_W)
  ) u_fsm (
    .clk          (clk),
    .rst          (rst),
    .start_req    (start_req),
    .mode_sel     (mode_sel),
    .assert_ms    (assert_ms),
    .wake_ms      (wake_ms),
    .run_ms       (run_ms),
    .rst_drive_en (rst_drive_en),
    .ext_halt     (ext_halt),
    .tmr_done     (tmr_done),
    .tmr_clear    (tmr_clear),
    .tmr_target   (tmr_target),
    .state        (state),
    .drive_en     (drive_en)
  );

  boot_pin_drv u_pins (
    .clk        (clk),
    .rst        (rst),
    .state      (state),
    .drive_en   (drive_en),
    .trst_pp    (trst_push_pull),
    .sys_rst_oe (sys_rst_oe),
    .trst_oe    (trst_oe),
    .trst_lvl   (trst_lvl),
    .halt_req   (halt_req),
    .init_ready (init_ready),
    .busy       (busy),
    .running    (running)
  );

endmodule

// File: tb/tgt_boot_seq_test.sv
`timescale 1ns/1ps
module tgt_boot_seq_test;

  localparam int DLY_W = 4;
  localparam int RUN_W = 8;
  localparam int RMIN  = 4;
  localparam int RMAX  = 12;
  localparam int ADEF  = 3;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ms_tick = 1'b0, start_req = 1'b0, ext_halt = 1'b0;
  logic [1:0] mode_sel = 2'd0;
  logic [DLY_W-1:0] assert_ms = '0, wake_ms = '0;
  logic [RUN_W-1:0] run_ms = '0;
  logic rst_drive_en = 1'b1, trst_push_pull = 1'b0;
  logic sys_rst_oe, trst_oe, trst_lvl, halt_req, init_ready, busy, running;

  int errors = 0, checks = 0, halt_cnt = 0, cyc = 0;

  always #4 clk = ~clk;

  tgt_boot_seq #(.DLY_W(DLY_W), .RUN_W(RUN_W), .RUN_MIN(RMIN), .RUN_MAX(RMAX),
                 .DEF_ASSERT_MS(ADEF)) uut (
    .clk(clk), .rst(rst), .ms_tick(ms_tick), .start_req(start_req),
    .mode_sel(mode_sel), .assert_ms(assert_ms), .wake_ms(wake_ms), .run_ms(run_ms),
    .rst_drive_en(rst_drive_en), .trst_push_pull(trst_push_pull), .ext_halt(ext_halt),
    .sys_rst_oe(sys_rst_oe), .trst_oe(trst_oe), .trst_lvl(trst_lvl), .halt_req(halt_req),
    .init_ready(init_ready), .busy(busy), .running(running));

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (halt_req) halt_cnt <= halt_cnt + 1;
    if (cyc >= 150000) begin
      errors = errors + 1;
      $display("FAIL watchdog: run hung, act=%0d exp=<150000 cycles", cyc);
      $display("Result: errors=%0d of %0d checks", errors, checks + 1);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: act=%0d exp=%0d", tag, act, exp);
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) begin
      ms_tick = 1'b1; @(negedge clk);
      ms_tick = 1'b0; @(negedge clk);
    end
  endtask

  task automatic do_start();
    start_req = 1'b1; @(negedge clk);
    start_req = 1'b0; idle(2);
  endtask

  task automatic do_halt();
    ext_halt = 1'b1; @(negedge clk);
    ext_halt = 1'b0;
  endtask

  initial begin
    int avals[4];
    int rvals[3];
    int k;
    avals = '{0, 1, 2, 5};
    rvals = '{1, 7, 200};
    k = 0;
    idle(3);
    rst = 1'b0;
    idle(2);
    // R1 reset state
    chk(!sys_rst_oe && !trst_oe && !trst_lvl, "R1 pins idle",
        {sys_rst_oe, trst_oe, trst_lvl}, 0);
    chk(!halt_req && !init_ready && !busy && !running, "R1 flags idle",
        {halt_req, init_ready, busy, running}, 0);

    for (int m = 0; m < 3; m++) begin
      for (int ai = 0; ai < 4; ai++) begin
        for (int w = 0; w <= 2; w += 2) begin
          int aeff, reff, h0;
          bit drv, pp;
          drv = (k % 3) != 2;
          pp  = (k % 2) == 1;
          mode_sel = 2'(m); assert_ms = DLY_W'(avals[ai]); wake_ms = DLY_W'(w);
          run_ms = RUN_W'(rvals[k % 3]); rst_drive_en = drv; trst_push_pull = pp;
          aeff = (avals[ai] == 0) ? ADEF : avals[ai];
          reff = (rvals[k % 3] < RMIN) ? RMIN : (rvals[k % 3] > RMAX) ? RMAX : rvals[k % 3];
          h0 = halt_cnt;
          do_start();
          chk(sys_rst_oe == drv, "R2/R3 reset pulled per drive enable", sys_rst_oe, drv);
          chk(trst_oe && !trst_lvl, "R4 TRST asserted", {trst_oe, trst_lvl}, 2);
          chk(busy && !init_ready, "R10 busy, ready cleared", {busy, init_ready}, 2);
          if (aeff > 1) begin
            tick(aeff - 1);
            chk(sys_rst_oe == drv && trst_oe && !trst_lvl, "R2 still held before last tick",
                sys_rst_oe, drv);
          end
          tick(1);
          chk(!sys_rst_oe, "R2 released after assert ticks", sys_rst_oe, 0);
          chk(trst_oe == pp && trst_lvl == pp, "R4 TRST released",
              {trst_oe, trst_lvl}, pp ? 3 : 0);
          if (w > 0) begin
            tick(w - 1);
            chk(halt_cnt == h0 && busy && !running, "R5 wake wait not over",
                halt_cnt - h0, 0);
            tick(1);
          end
          if (m == 0) begin
            idle(3);
            chk(halt_cnt == h0 + 1, "R6 one halt pulse", halt_cnt - h0, 1);
            chk(init_ready && !busy, "R6 ready", {init_ready, busy}, 2);
          end else if (m == 1) begin
            idle(2);
            tick(reff - 1);
            chk(halt_cnt == h0 && busy && !init_ready, "R7 still running timed",
                halt_cnt - h0, 0);
            tick(1);
            idle(3);
            chk(halt_cnt == h0 + 1 && init_ready, "R8 clamped run time then halt",
                halt_cnt - h0, 1);
          end else begin
            idle(3);
            chk(running && !busy && halt_cnt == h0, "R9 free running",
                {running, busy}, 2);
            tick(4);
            chk(running && halt_cnt == h0, "R9 no halt without request", halt_cnt - h0, 0);
            do_halt();
            idle(3);
            chk(halt_cnt == h0 + 1 && init_ready && !running, "R9 halted on request",
                halt_cnt - h0, 1);
          end
          k++;
        end
      end
    end

    // R9: ext_halt in ready has no effect
    begin
      int h0;
      h0 = halt_cnt;
      do_halt(); idle(3);
      chk(halt_cnt == h0 && init_ready, "R9 ext_halt ignored when ready", halt_cnt - h0, 0);
    end

    // R10/R11: start while busy ignored, config captured
    begin
      int h0;
      h0 = halt_cnt;
      mode_sel = 2'd0; assert_ms = 4'd5; wake_ms = 4'd0; rst_drive_en = 1'b1;
      trst_push_pull = 1'b0;
      do_start();
      tick(2);
      assert_ms = 4'd15; mode_sel = 2'd2; rst_drive_en = 1'b0;
      do_start();
      do_halt();
      idle(1);
      chk(sys_rst_oe && halt_cnt == h0, "R10 restart and halt ignored while busy",
          sys_rst_oe, 1);
      tick(2);
      chk(sys_rst_oe, "R11 captured assert time still counting", sys_rst_oe, 1);
      tick(1);
      chk(!sys_rst_oe, "R11 release at captured count", sys_rst_oe, 0);
      idle(3);
      chk(halt_cnt == h0 + 1 && init_ready && !running, "R11 captured mode kept",
          halt_cnt - h0, 1);
    end

    // R10: restart from running state
    begin
      mode_sel = 2'd3; assert_ms = 4'd1; wake_ms = 4'd0; rst_drive_en = 1'b1;
      do_start(); tick(1); idle(3);
      chk(running, "R9 mode 3 is free run", running, 1);
      do_start();
      chk(sys_rst_oe && busy && !running, "R10 restart from running",
          {sys_rst_oe, busy, running}, 6);
      tick(1); idle(3);
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule